// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous memory whose host side is a shared data bus, split here into an input word, an output word and a drive-enable. A read or a write may be started on every clock with no idle cycle between a read and a write. This works because write data trails its address by two enabled clocks, the same distance at which read data is captured. The two directions therefore use the bus in the same slot of the pipeline.

An access starts on a cycle that loads an external address. Later cycles with the advance strobe high continue it as a burst of the same direction, stepping the two lowest address bits in linear or interleaved order. Each 36-bit word has four lanes of nine bits (eight data bits and a parity bit). A write updates only the lanes whose active-low select is low in its data cycle. A high clock enable stalls the whole pipeline. A read issued right after a write to the same word sees that write's lanes, merged with the stored contents.

Top module: `nbt_sram`

## Requirements
- R1: With clock enable low, the advance strobe low, chip enable low and write enable high, an edge E0 loads the address and starts a read. The word is on `dq_o` from the next enabled edge E1 until the enabled edge after it, and the host captures it there.
- R2: With clock enable low, the advance strobe low, chip enable low and write enable low, an edge E0 loads the address and starts a write. The write data on `dq_i` and the lane selects `bsel_n` are both sampled at the second enabled edge E2.
- R3: In a write's data cycle, lane i is bits 9i+8..9i. It is written only when `bsel_n[i]` is 0; the other lanes keep their old contents.
- R4: An enabled edge with the advance strobe high ignores `ce_n` and `we_n` and repeats the direction of the last load. If the last load was a deselect, it starts nothing.
- R5: The k-th advance cycle after a load (k counted mod 4) uses the loaded upper address bits. Its low two bits are (base+k) mod 4 when `burst_lin` is 1, and base XOR k when `burst_lin` is 0.
- R6: A read loaded on the enabled edge right after a write load to the same address returns that write's selected lanes, merged with the stored lanes.
- R7: While `cen_n` is high, no state changes: outputs hold, no write commits and the pipeline does not move.
- R8: A load with `ce_n` high is a deselect: no access starts, and `dq_oe` is low after the following enabled edge.
- R9: `dq_oe` is high only while read data is valid and `oe_n` is low. It is low throughout a write's data cycle, whatever the level of `oe_n`.
- R10: After reset the block is deselected: `dq_oe` is low, and advance cycles start no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Active-low clock enable; high stalls the pipeline |
| ce_n | input | 1 | Active-low chip enable, used on load cycles |
| we_n | input | 1 | Active-low write enable, used on load cycles |
| adv_ld | input | 1 | High: continue burst; low: load external address |
| burst_lin | input | 1 | 1 selects linear burst order, 0 interleaved |
| bsel_n | input | LANES | Active-low lane write selects, sampled with write data |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | External address |
| dq_i | input | LANES*LANE_W | Bus value seen by the memory (write data) |
| dq_o | output | LANES*LANE_W | Read data to be driven on the bus |
| dq_oe | output | 1 | Bus drive enable for dq_o |

## Verification
The hardest case to reach is a read that overlaps a write still in the pipeline. The write's data has to arrive on the same edge at which the read's word is captured, so only the one-cycle write-then-read spacing exercises the merge path. The stimulus holds that spacing and sweeps all sixteen lane-select patterns over a pre-filled word, then alternates write and read on every cycle with random selects. Stalls are placed between the address and data phases of pending writes and reads, to confirm that the two-clock distance counts enabled edges only.

// File: rtl/nbt_sram.sv
module nbt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cen_n,
  input  logic                      ce_n,
  input  logic                      we_n,
  input  logic                      adv_ld,
  input  logic                      burst_lin,
  input  logic [LANES-1:0]          bsel_n,
  input  logic                      oe_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   dq_i,
  output logic [LANES*LANE_W-1:0]   dq_o,
  output logic                      dq_oe
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [1:0] {K_IDLE, K_RD, K_WR} kind_t;

  logic [DW-1:0]     mem [DEPTH];
  kind_t             last_kind, cmd_kind;
  logic [ADDR_W-1:0] bur_addr, cmd_addr, a_addr, b_addr;
  logic [1:0]        bur_cnt, nxt_cnt, bur_low;
  logic              a_valid, a_wr, b_valid, out_valid;
  logic [DW-1:0]     rd_word;

  assign nxt_cnt  = bur_cnt + 2'd1;
  assign bur_low  = burst_lin ? (bur_addr[1:0] + nxt_cnt) : (bur_addr[1:0] ^ nxt_cnt);
  assign cmd_addr = adv_ld ? {bur_addr[ADDR_W-1:2], bur_low} : addr;
  assign cmd_kind = adv_ld ? last_kind : (ce_n ? K_IDLE : (we_n ? K_RD : K_WR));
  assign dq_oe    = out_valid && !oe_n;

  always_comb begin
    rd_word = mem[a_addr];
    for (int i = 0; i < LANES; i++)
      if (b_valid && b_addr == a_addr && !bsel_n[i])
        rd_word[i*LANE_W +: LANE_W] = dq_i[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_kind <= K_IDLE;
      bur_addr  <= '0;
      bur_cnt   <= '0;
      a_valid   <= 1'b0;
      a_wr      <= 1'b0;
      a_addr    <= '0;
      b_valid   <= 1'b0;
      b_addr    <= '0;
      out_valid <= 1'b0;
      dq_o      <= '0;
    end else if (!cen_n) begin
      if (!adv_ld) begin
        bur_addr  <= addr;
        bur_cnt   <= '0;
        last_kind <= cmd_kind;
      end else begin
        bur_cnt   <= nxt_cnt;
      end
      a_valid   <= cmd_kind != K_IDLE;
      a_wr      <= cmd_kind == K_WR;
      a_addr    <= cmd_addr;
      b_valid   <= a_valid && a_wr;
      b_addr    <= a_addr;
      out_valid <= a_valid && !a_wr;
      if (a_valid && !a_wr) dq_o <= rd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!cen_n && b_valid)
      for (int i = 0; i < LANES; i++)
        if (!bsel_n[i])
          mem[b_addr][i*LANE_W +: LANE_W] <= dq_i[i*LANE_W +: LANE_W];
  end

  assert_wr_phase_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> !dq_oe);

  assert_deselect_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && ce_n) |=> !a_valid);

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> ($stable(dq_o) && $stable(out_valid) && $stable(a_addr) && $stable(b_valid)));

  assert_burst_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld && last_kind == K_RD) |=> (a_valid && !a_wr));

  assert_load_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && !ce_n && we_n) |=> (a_valid && !a_wr && a_addr == $past(addr)));

  assert_load_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && !ce_n && !we_n) |=> (a_valid && a_wr));
endmodule

// File: tb/nbt_sram_bench.sv
module nbt_sram_bench;
  localparam int CLK_P = 10;
  localparam int DW = 36;

  logic clk, rst_n, cen_n, ce_n, we_n, adv_ld, burst_lin, oe_n, dq_oe;
  logic [3:0]    bsel_n;
  logic [5:0]    addr;
  logic [DW-1:0] dq_i, dq_o;

  nbt_sram u_nbt_sram (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce_n(ce_n), .we_n(we_n),
    .adv_ld(adv_ld), .burst_lin(burst_lin), .bsel_n(bsel_n), .oe_n(oe_n),
    .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0, t = 0;
  logic [DW-1:0] model [64];
  bit pw_v [4];
  int pw_a [4];
  bit rd_v [4];
  int rd_a [4];
  int kind = 0, base = 0, cnt = 0;

  function automatic logic [DW-1:0] mix(int n);
    logic [31:0] h;
    h = n * 32'h9E37_79B1;
    return {n[3:0], h} ^ 36'h5_0A0F_33C1;
  endfunction

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit ce, bit we, bit adv, int ad, logic [3:0] bs, bit oe, bit lin, string tag);
    int slot, ea;
    logic [DW-1:0] d;
    @(negedge clk);
    cen_n = 0; ce_n = ce; we_n = we; adv_ld = adv; addr = ad[5:0];
    burst_lin = lin; oe_n = oe; bsel_n = bs;
    if (!adv) begin
      base = ad; cnt = 0; ea = ad;
      kind = ce ? 0 : (we ? 1 : 2);
    end else begin
      cnt = (cnt + 1) % 4;
      ea = (base & ~3) | (lin ? ((base + cnt) & 3) : ((base ^ cnt) & 3));
    end
    slot = t % 4;
    d = mix(t);
    if (pw_v[slot]) begin
      dq_i = d;
      for (int i = 0; i < 4; i++)
        if (!bs[i]) model[pw_a[slot]][i*9 +: 9] = d[i*9 +: 9];
      pw_v[slot] = 0;
    end else dq_i = ~d;
    if (kind == 2) begin pw_v[(t+2)%4] = 1; pw_a[(t+2)%4] = ea; end
    if (kind == 1) begin rd_v[(t+1)%4] = 1; rd_a[(t+1)%4] = ea; end
    @(posedge clk);
    #(CLK_P/4);
    chk(dq_oe == (rd_v[slot] && !oe), $sformatf("%s/R9 dq_oe", tag), {35'd0, dq_oe}, {35'd0, rd_v[slot] && !oe});
    if (rd_v[slot]) chk(dq_o === model[rd_a[slot]], $sformatf("%s read addr %0d", tag, rd_a[slot]), dq_o, model[rd_a[slot]]);
    rd_v[slot] = 0;
    t++;
  endtask

  task automatic freeze(int n);
    logic [DW-1:0] po;
    logic pe;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      po = dq_o; pe = dq_oe;
      cen_n = 1; ce_n = $urandom; we_n = $urandom; adv_ld = $urandom;
      addr = $urandom; bsel_n = $urandom; dq_i = {$urandom, 4'h0};
      @(posedge clk);
      #(CLK_P/4);
      chk(dq_o === po && dq_oe === pe, "R7 stall hold", dq_o, po);
    end
  endtask

  task automatic desel(int n);
    for (int k = 0; k < n; k++) step(1, 1, 0, 0, 4'hF, 0, 1, "R8");
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; cen_n = 0; ce_n = 1; we_n = 1; adv_ld = 0; burst_lin = 1;
    oe_n = 0; addr = 0; bsel_n = '1; dq_i = '0;
    for (int i = 0; i < 4; i++) begin pw_v[i] = 0; rd_v[i] = 0; end
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    chk(dq_oe == 0, "R10 reset dq_oe", {35'd0, dq_oe}, 0);
    @(negedge clk); rst_n = 1;
    // R10: advance after reset starts nothing
    for (int k = 0; k < 3; k++) step(0, 1, 1, 0, 4'h0, 0, 1, "R10");
    // R2/R4: fill with linear write bursts, ce/we ignored on advance
    for (int b = 0; b < 16; b++) begin
      step(0, 0, 0, b*4, 4'h0, 0, 1, "R2");
      for (int k = 0; k < 3; k++) step(1, 1, 1, 0, 4'h0, 0, 1, "R4");
    end
    step(1, 1, 0, 0, 4'h0, 0, 1, "R8");
    step(1, 1, 0, 0, 4'h0, 0, 1, "R8");
    // R5: interleaved and linear read bursts from every base
    for (int a = 0; a < 64; a++) begin
      step(0, 1, 0, a, $urandom, 0, 0, "R1");
      for (int k = 0; k < 3; k++) step(1, 0, 1, 0, $urandom, 0, 0, "R5");
    end
    for (int a = 0; a < 64; a++) begin
      step(0, 1, 0, a, $urandom, 0, 1, "R1");
      for (int k = 0; k < 5; k++) step(1, 0, 1, 0, $urandom, 0, 1, "R5");
    end
    desel(1);
    // R3: every lane mask on a stored word
    for (int m = 0; m < 16; m++) begin
      step(0, 0, 0, m, $urandom, 0, 1, "R3");
      step(1, 1, 0, 0, $urandom, 0, 1, "R3");
      step(1, 1, 0, 0, m[3:0], 0, 1, "R3");
      step(0, 1, 0, m, $urandom, 0, 1, "R3");
      desel(1);
    end
    // R6: write then read same address, merge from pipeline
    for (int m = 0; m < 16; m++) begin
      step(0, 0, 0, 16 + m, $urandom, 0, 1, "R6");
      step(0, 1, 0, 16 + m, $urandom, 0, 1, "R6");
      step(1, 1, 0, 0, m[3:0], 0, 1, "R6");
      desel(1);
    end
    for (int k = 0; k < 32; k++)
      step(0, k[0] ? 1'b1 : 1'b0, 0, 32 + (k/2) % 4, $urandom, 0, 1, "R6");
    desel(2);
    // R7: stalls inside pending read and write
    step(0, 1, 0, 5, 4'hF, 0, 1, "R7");
    freeze(3);
    step(1, 1, 0, 0, 4'hF, 0, 1, "R7");
    step(0, 0, 0, 7, 4'hF, 0, 1, "R7");
    freeze(2);
    step(1, 1, 0, 0, 4'hF, 0, 1, "R7");
    freeze(2);
    step(1, 1, 0, 0, 4'h5, 0, 1, "R7");
    step(0, 1, 0, 7, 4'hF, 0, 1, "R7");
    freeze(2);
    desel(1);
    // R9: output enable gating on a read burst
    step(0, 1, 0, 12, 4'hF, 1, 1, "R9");
    for (int k = 0; k < 7; k++) step(1, 1, 1, 0, 4'hF, k[0], 1, "R9");
    desel(1);
    // R2/R3: burst write with per-cycle lane selects, then read back
    step(0, 0, 0, 40, 4'hF, 0, 0, "R2");
    step(1, 1, 1, 0, 4'hF, 0, 0, "R2");
    step(1, 1, 1, 0, 4'hE, 0, 0, "R3");
    step(1, 1, 1, 0, 4'hB, 0, 0, "R3");
    step(1, 1, 0, 0, 4'h6, 0, 0, "R3");
    step(1, 1, 0, 0, 4'h0, 0, 0, "R3");
    step(0, 1, 0, 40, 4'hF, 0, 0, "R2");
    for (int k = 0; k < 3; k++) step(1, 1, 1, 0, 4'hF, 0, 0, "R2");
    // R8/R4: deselect mid-burst, advance afterwards starts nothing
    step(0, 1, 0, 20, 4'hF, 0, 1, "R8");
    step(1, 1, 1, 0, 4'hF, 0, 1, "R8");
    step(1, 0, 0, 0, 4'hF, 0, 1, "R8");
    for (int k = 0; k < 3; k++) step(0, 1, 1, 0, 4'hF, 0, 1, "R4");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule